// File: doc/BRIEF.md
# Fine-Adjust Time-of-Day Counter

This block keeps a free-running time-of-day value for precision time protocol work. Each cycle of its 125 MHz clock is one tick. A tick adds a fixed nominal step of 8 ns to a 40-bit nanosecond count. Below that count sits a 32-bit sub-nanosecond residue. Software programs a signed correction, and the block adds it to or takes it from the residue on every tick, which trims the clock rate without ever moving time backwards.

Software reaches the block through a small register bus with one strobe for writes and one for reads. There are five word addresses: the residue word, the low and high words of the nanosecond count, the rate-adjust word and an auxiliary control word that holds the halt bit. Reading the residue word freezes a copy of the whole 72-bit time, so the low and high reads that follow it return that same instant. Writes to the low and residue words are held back until the high word is written. The high-word write then loads all 72 bits at once.

Top module: `fine_tod_clock`

## Requirements
- R1: After a synchronous reset the time is zero, the rate word is zero, and the auxiliary word reads 0x8000_0000 (halted).
- R2: While bit 31 of the auxiliary word (address 4) is 1, the time does not change except by a time load.
- R3: When running with a zero correction magnitude, each clock edge adds exactly 8 to the nanosecond count and leaves the residue unchanged. Read data appears on bus_rdata one edge after the read strobe.
- R4: With rate bit 31 clear, each tick adds rate bits 30:0 to the residue. A carry out of the residue adds one more nanosecond, so that tick steps 9 ns.
- R5: With rate bit 31 set, each tick subtracts rate bits 30:0 from the residue. A borrow removes one nanosecond, so that tick steps 7 ns and the count never decreases.
- R6: The nanosecond count wraps from 2^40-1 to zero. In the high word (address 2), bits 31:8 always read 0 and bits 7:0 carry count bits 39:32.
- R7: A read of the residue word (address 0) latches the full 72-bit time. Later reads of the low word (address 1, count bits 31:0) and the high word return that latched copy until the next residue read.
- R8: Writes to address 0 or 1 only fill holding registers. A write to address 2 loads the count and residue from the high data and both holding values on that edge, and it overrides the tick of that edge.
- R9: A rate write (address 3) lands on the edge of its strobe. The tick on that edge still uses the old rate, and the write leaves the residue unchanged.
- R10: The rate and auxiliary words read back the values last written. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one 8 ns tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Writes take effect on the clock edge that samples their strobe. A load or halt change therefore first alters the tick of the following edge, and a rate change first alters the tick after its own edge. Read data is registered, so it is due one edge after the read strobe. For a residue read, the latched time is the value the counter held just before that edge. The bench drives each strobe for one cycle starting at a falling edge and samples bus_rdata at the next falling edge. A cycle-accurate reference model updates on the same rising edges, so each sampled value is compared with the model state for exactly that edge.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    localparam int DATA_W = 32;
    localparam int NS_W   = 40;
    localparam int FRAC_W = 32;
    localparam int ADDR_W = 3;
    localparam int MAG_W  = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_FRAC = 3'd0,
        A_LOW  = 3'd1,
        A_HIGH = 3'd2,
        A_RATE = 3'd3,
        A_AUX  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } rate_t;

    // One tick: residue +/- magnitude, carry or borrow folds into the count.
    function automatic tod_t tod_advance(tod_t cur, rate_t r, logic [NS_W-1:0] step);
        logic [FRAC_W:0] acc;
        tod_t nxt;
        if (!r.neg) begin
            acc    = {1'b0, cur.frac} + {{(FRAC_W+1-MAG_W){1'b0}}, r.mag};
            nxt.ns = cur.ns + step + {{(NS_W-1){1'b0}}, acc[FRAC_W]};
        end else begin
            acc    = {1'b0, cur.frac} - {{(FRAC_W+1-MAG_W){1'b0}}, r.mag};
            nxt.ns = cur.ns + step - {{(NS_W-1){1'b0}}, acc[FRAC_W]};
        end
        nxt.frac = acc[FRAC_W-1:0];
        return nxt;
    endfunction

endpackage

// File: rtl/ftc_regs.sv
module ftc_regs
    import ftc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output rate_t             rate,
    output logic              halt,
    output logic              load,
    output tod_t              load_val
);

    localparam int HI_W = NS_W - DATA_W;

    logic [DATA_W-1:0] hold_low;
    logic [FRAC_W-1:0] hold_frac;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate      <= '0;
            halt      <= 1'b1;
            hold_low  <= '0;
            hold_frac <= '0;
        end else if (wr) begin
            case (addr)
                A_FRAC: hold_frac <= wdata;
                A_LOW:  hold_low  <= wdata;
                A_RATE: rate      <= rate_t'(wdata);
                A_AUX:  halt      <= wdata[DATA_W-1];
                default: ;
            endcase
        end
    end

    assign load     = wr && (addr == A_HIGH);
    assign load_val = '{ns: {wdata[HI_W-1:0], hold_low}, frac: hold_frac};

    p_rate_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_RATE) |=> (rate == rate_t'($past(wdata))));

    p_aux_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_AUX) |=> (halt == $past(wdata[DATA_W-1])));

endmodule

// File: rtl/ftc_counter.sv
module ftc_counter
    import ftc_pkg::*;
#(
    parameter int STEP_NS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  halt,
    input  rate_t rate,
    input  logic  load,
    input  tod_t  load_val,
    output tod_t  now
);

    localparam logic [NS_W-1:0] STEP = NS_W'(STEP_NS);

    always_ff @(posedge clk) begin
        if (rst)        now <= '0;
        else if (load)  now <= load_val;
        else if (!halt) now <= tod_advance(now, rate, STEP);
    end

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> (now == $past(now)));

    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (now == $past(load_val)));

    p_nominal_r3: assert property (@(posedge clk) disable iff (rst)
        (!halt && !load && rate.mag == '0) |=>
        ((now.ns - $past(now.ns)) == STEP && now.frac == $past(now.frac)));

    p_pos_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!halt && !load && !rate.neg) |=>
        ((now.ns - $past(now.ns)) == STEP || (now.ns - $past(now.ns)) == STEP + 1'b1));

    p_neg_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!halt && !load && rate.neg) |=>
        ((now.ns - $past(now.ns)) == STEP || (now.ns - $past(now.ns)) == STEP - 1'b1));

endmodule

// File: rtl/ftc_readout.sv
module ftc_readout
    import ftc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  tod_t              now,
    input  rate_t             rate,
    input  logic              halt,
    output logic [DATA_W-1:0] rdata
);

    tod_t snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            rdata <= '0;
        end else if (rd) begin
            case (addr)
                A_FRAC: begin
                    snap  <= now;
                    rdata <= now.frac;
                end
                A_LOW:   rdata <= snap.ns[DATA_W-1:0];
                A_HIGH:  rdata <= DATA_W'(snap.ns[NS_W-1:DATA_W]);
                A_RATE:  rdata <= rate;
                A_AUX:   rdata <= {halt, {(DATA_W-1){1'b0}}};
                default: rdata <= '0;
            endcase
        end
    end

    p_high_reserved_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_HIGH) |=> (rdata[DATA_W-1:NS_W-DATA_W] == '0));

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == A_FRAC) |=> $stable(snap));

    p_snap_take_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_FRAC) |=> (snap == $past(now)));

endmodule

// File: rtl/fine_tod_clock.sv
module fine_tod_clock
    import ftc_pkg::*;
#(
    parameter int STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    rate_t rate;
    logic  halt;
    logic  load;
    tod_t  load_val;
    tod_t  now;

    ftc_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .rate(rate), .halt(halt), .load(load), .load_val(load_val)
    );

    ftc_counter #(.STEP_NS(STEP_NS)) u_count (
        .clk(clk), .rst(rst), .halt(halt), .rate(rate),
        .load(load), .load_val(load_val), .now(now)
    );

    ftc_readout u_read (
        .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd),
        .now(now), .rate(rate), .halt(halt), .rdata(bus_rdata)
    );

endmodule

// File: tb/sim_fine_tod_clock.sv
module sim_fine_tod_clock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fine_tod_clock u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Reference model: time as one 72-bit quantity in units of 2^-32 ns.
    logic [71:0] m_time, m_snap;
    logic [31:0] m_rate, m_hlo, m_hfr;
    logic        m_halt;

    always @(posedge clk) begin
        if (rst) begin
            m_time <= '0; m_snap <= '0; m_rate <= '0;
            m_hlo <= '0; m_hfr <= '0; m_halt <= 1'b1;
        end else begin
            if (bus_wr && bus_addr == 3'd2)
                m_time <= {bus_wdata[7:0], m_hlo, m_hfr};
            else if (!m_halt) begin
                if (m_rate[31]) m_time <= m_time + {40'd8, 32'd0} - {41'd0, m_rate[30:0]};
                else            m_time <= m_time + {40'd8, 32'd0} + {41'd0, m_rate[30:0]};
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_hfr  <= bus_wdata;
                    3'd1: m_hlo  <= bus_wdata;
                    3'd3: m_rate <= bus_wdata;
                    3'd4: m_halt <= bus_wdata[31];
                    default: ;
                endcase
            end
            if (bus_rd && bus_addr == 3'd0) m_snap <= m_time;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_time_chk(string req);
        logic [31:0] d;
        rd_reg(3'd0, d); chk(req, "residue", d, m_snap[31:0]);
        rd_reg(3'd1, d); chk(req, "low", d, m_snap[63:32]);
        rd_reg(3'd2, d); chk(req, "high", d, {24'd0, m_snap[71:64]});
    endtask

    task automatic load_time(logic [7:0] hi, logic [31:0] lo, logic [31:0] fr);
        wr_reg(3'd0, fr);
        wr_reg(3'd1, lo);
        wr_reg(3'd2, {24'd0, hi});
    endtask

    task automatic t_reset_r1;
        logic [31:0] d;
        rd_reg(3'd3, d); chk("R1", "rate after reset", d, 32'h0);
        rd_reg(3'd4, d); chk("R1", "aux after reset", d, 32'h8000_0000);
        rd_reg(3'd0, d); chk("R1", "residue after reset", d, 32'h0);
        rd_reg(3'd1, d); chk("R1", "low after reset", d, 32'h0);
        rd_reg(3'd6, d); chk("R10", "unmapped address", d, 32'h0);
    endtask

    task automatic t_halted_r2;
        logic [31:0] d;
        repeat (20) @(negedge clk);
        rd_reg(3'd0, d); chk("R2", "residue while halted", d, 32'h0);
        rd_reg(3'd1, d); chk("R2", "low while halted", d, 32'h0);
    endtask

    task automatic t_load_r8;
        logic [31:0] d;
        wr_reg(3'd0, 32'h0000_1234);
        wr_reg(3'd1, 32'hFFFF_FFF0);
        repeat (10) @(negedge clk);
        rd_reg(3'd1, d); chk("R8", "holding write leaves time", d, 32'h0);
        wr_reg(3'd2, 32'h0000_0005);
        rd_reg(3'd0, d); chk("R8", "loaded residue", d, 32'h0000_1234);
        rd_reg(3'd1, d); chk("R8", "loaded low", d, 32'hFFFF_FFF0);
        rd_reg(3'd2, d); chk("R8", "loaded high", d, 32'h0000_0005);
    endtask

    task automatic t_rate_write_r9;
        logic [31:0] d;
        wr_reg(3'd3, 32'h1234_5678);
        rd_reg(3'd0, d); chk("R9", "rate write keeps residue", d, 32'h0000_1234);
        rd_reg(3'd3, d); chk("R10", "rate readback", d, 32'h1234_5678);
        wr_reg(3'd3, 32'h0);
    endtask

    task automatic t_nominal_r3;
        logic [31:0] a, b;
        load_time(8'h0, 32'h0, 32'h0);
        wr_reg(3'd4, 32'h0);
        rd_reg(3'd4, a); chk("R10", "aux readback", a, 32'h0);
        rd_reg(3'd0, a);
        rd_reg(3'd1, a);
        repeat (9) @(negedge clk);
        rd_reg(3'd0, b);
        rd_reg(3'd1, b);
        // Residue reads 13 edges apart: 13 ticks of 8 ns.
        chk("R3", "8 ns per tick", b - a, 32'd104);
        read_time_chk("R3");
    endtask

    task automatic t_pos_r4;
        wr_reg(3'd3, 32'h7FFF_FFFF);
        repeat (100) @(negedge clk);
        read_time_chk("R4");
        repeat (37) @(negedge clk);
        read_time_chk("R4");
    endtask

    task automatic t_neg_r5;
        wr_reg(3'd3, 32'hFFFF_FFFF);
        repeat (100) @(negedge clk);
        read_time_chk("R5");
        wr_reg(3'd3, 32'h8000_0001);
        repeat (23) @(negedge clk);
        read_time_chk("R5");
    endtask

    task automatic t_wrap_r6;
        logic [31:0] d;
        wr_reg(3'd4, 32'h8000_0000);
        wr_reg(3'd3, 32'h0);
        load_time(8'hFF, 32'hFFFF_FFF0, 32'h0);
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd4, 32'h8000_0000);
        // Exactly two ticks ran: 0xFF_FFFF_FFF0 + 16 wraps to 0.
        rd_reg(3'd0, d); chk("R6", "residue after wrap", d, 32'h0);
        rd_reg(3'd1, d); chk("R6", "low after wrap", d, 32'h0);
        rd_reg(3'd2, d); chk("R6", "high after wrap", d, 32'h0);
        read_time_chk("R6");
    endtask

    task automatic t_latch_r7;
        logic [31:0] d;
        load_time(8'h3C, 32'h89AB_CDEF, 32'h8000_0000);
        wr_reg(3'd3, 32'h4000_0000);
        wr_reg(3'd4, 32'h0);
        rd_reg(3'd0, d); chk("R7", "residue", d, m_snap[31:0]);
        repeat (30) @(negedge clk);
        rd_reg(3'd1, d); chk("R7", "low from snapshot", d, m_snap[63:32]);
        checks++;
        if (d == m_time[63:32]) begin
            fails++;
            $display("FAIL R7 low followed live time: actual=%h expected=%h", d, m_snap[63:32]);
        end
        rd_reg(3'd2, d); chk("R7", "high from snapshot", d, {24'd0, m_snap[71:64]});
        chk("R6", "high reserved bits", {8'd0, d[31:8]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_halted_r2();
        t_load_r8();
        t_rate_write_r9();
        t_nominal_r3();
        t_pos_r4();
        t_neg_r5();
        t_wrap_r6();
        t_latch_r7();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule